// File: doc/BRIEF.md
# Iterative Fast Hadamard Transform Engine

This block computes a fast Hadamard transform of a vector of POINTS signed fixed-point samples, DATAWIDTH bits each, kept in one internal storage array. While `run_en` is low, a host fills the array through the write port (`wr_en`, `wr_addr`, `wr_data`). The host then raises `run_en`, and the engine makes log_R(POINTS) in-place passes over the array, where R is the RADIX parameter. In each pass every point is fetched once, in groups of R operands. Each group goes through a radix-R butterfly and the results are written back to the addresses they came from.

Each butterfly output is rounded and divided by R, so the word width stays DATAWIDTH and the final vector is the Hadamard transform scaled by 1/POINTS. Results are left in natural index order. When the last write of the last pass has landed, `xform_done` rises. The host drops `run_en` and reads the results through the read port (`rd_en`, `rd_addr`, `rd_data`). Dropping `run_en` in the middle of a transform freezes the engine, and raising it again resumes from the same point.

Top module: `fht_engine`

## Requirements
- R1: While `run_en` is low, `wr_en` high stores `wr_data` at `wr_addr` at the clock edge. `rd_en` high loads the word at `rd_addr` into `rd_data` at the next clock edge.
- R2: A `wr_en` request made while `run_en` is high leaves the array unchanged.
- R3: Pass p (p = 0 .. PASSES-1, where PASSES = log_R(POINTS)) takes each group of R words whose addresses differ only in base-R digit p, at stride R^p, as x0..x(R-1) in increasing address order. It replaces word k of the group with (S_k + R/2) >>> log2(R). Here S_k is the sum over j of x_j, negated when popcount(k AND j) is odd. Results stay in natural address order.
- R4: When a rounded butterfly result exceeds the signed DATAWIDTH range, it is clamped to the most positive value (or the most negative value) instead of wrapping.
- R5: Count clock edges from the first edge that samples `run_en` high in the idle state. `xform_done` is first high after edge 1 + PASSES × (POINTS + RADIX + 1), that is, edge 208 with the default parameters.
- R6: An edge that samples `run_en` low during a transform freezes all engine progress. Each such edge delays `xform_done` by exactly one edge and leaves the results unchanged.
- R7: `xform_done` stays high while `run_en` stays high. It falls at the first edge that samples `run_en` low, and the engine returns to idle.
- R8: `rst` is asynchronous and active high. It drives `xform_done` and `rd_data` to zero at once and aborts any transform in progress. The array contents are not cleared.
- R9: `rd_data` keeps its value on every edge where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| run_en | input | 1 | Starts, continues or pauses the transform; low for host access |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | log2(POINTS) | Host write address |
| wr_data | input | DATAWIDTH | Host write data, two's complement |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | log2(POINTS) | Host read address |
| rd_data | output | DATAWIDTH | Registered host read data |
| xform_done | output | 1 | High once the transform has finished |

## Verification
The hardest condition to reach from the ports is a pause that falls while a butterfly group is half collected and earlier groups are still draining. From the outside it only shows up as a shifted completion time and intact results. The stimulus drops `run_en` partway through a pass for a fixed number of cycles. It then checks that the completion edge moves by exactly that number and that every result still matches the pass-by-pass model. Clamping is reached with alternating full-scale inputs, which drive the butterfly sums past the word range in the first pass.

// File: rtl/fht_pkg.sv
package fht_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } fht_state_t;

   // Sign of operand j in butterfly output k of a Sylvester kernel
   function automatic bit walsh_neg(input int k, input int j);
      return ($countones(k & j) % 2) == 1;
   endfunction

endpackage

// File: rtl/fht_addr_map.sv
// Maps a sequential pass index onto the array address of one butterfly operand.
// The low log2(R) index bits pick the operand; they are moved up to digit p.
module fht_addr_map #(
   parameter int ADDRW = 6,
   parameter int LOGR  = 2,
   parameter int PW    = 2
) (
   input  logic [ADDRW-1:0] idx,
   input  logic [PW-1:0]    pass,
   output logic [ADDRW-1:0] addr
);
   localparam logic [ADDRW-1:0] DIGIT_MASK = ADDRW'((1 << LOGR) - 1);

   int                 sh;
   logic [ADDRW-1:0]   opnd;
   logic [ADDRW-1:0]   grp;
   logic [ADDRW-1:0]   low_mask;

   always_comb begin
      sh       = int'(pass) * LOGR;
      opnd     = idx & DIGIT_MASK;
      grp      = idx >> LOGR;
      low_mask = (ADDRW'(1) << sh) - ADDRW'(1);
      addr     = ((grp >> sh) << (sh + LOGR)) | (opnd << sh) | (grp & low_mask);
   end

endmodule

// File: rtl/fht_kernel.sv
// Radix-R Sylvester butterfly with per-output rounding, divide by R and clamp.
module fht_kernel #(
   parameter int W = 12,
   parameter int R = 4
) (
   input  logic [R*W-1:0] vin,
   output logic [R*W-1:0] vout
);
   localparam int LOGR = $clog2(R);
   localparam int SW   = W + LOGR + 1;
   localparam logic signed [SW-1:0] HALF = SW'(R / 2);
   localparam logic signed [SW-1:0] MAXV = {{(LOGR + 2){1'b0}}, {(W - 1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = {{(LOGR + 2){1'b1}}, {(W - 1){1'b0}}};

   for (genvar k = 0; k < R; k++) begin : g_out
      logic signed [SW-1:0] acc;
      logic signed [SW-1:0] opx;
      logic signed [SW-1:0] rnd;
      always_comb begin
         acc = '0;
         for (int j = 0; j < R; j++) begin
            opx = {{(LOGR + 1){vin[j*W + W - 1]}}, vin[j*W +: W]};
            if (fht_pkg::walsh_neg(k, j)) acc = acc - opx;
            else                          acc = acc + opx;
         end
         rnd = (acc + HALF) >>> LOGR;
         if (rnd > MAXV)      vout[k*W +: W] = MAXV[W-1:0];
         else if (rnd < MINV) vout[k*W +: W] = MINV[W-1:0];
         else                 vout[k*W +: W] = rnd[W-1:0];
      end
   end

endmodule

// File: rtl/fht_bfly_stage.sv
// Collects R serially fetched operands, runs the kernel on the last arrival,
// and holds the R results for serial write-back.
module fht_bfly_stage #(
   parameter int W = 12,
   parameter int R = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 land_vld,
   input  logic [$clog2(R)-1:0] land_k,
   input  logic [W-1:0]         operand,
   input  logic [$clog2(R)-1:0] out_sel,
   output logic [W-1:0]         out_word
);
   localparam int LOGR = $clog2(R);

   logic [W-1:0]   coll [R];
   logic [W-1:0]   bank [R];
   logic [R*W-1:0] kin;
   logic [R*W-1:0] kout;
   logic           land_last;

   assign land_last = (land_k == LOGR'(R - 1));

   always_comb begin
      for (int j = 0; j < R - 1; j++) kin[j*W +: W] = coll[j];
      kin[(R-1)*W +: W] = operand;
   end

   fht_kernel #(.W(W), .R(R)) u_kernel (.vin(kin), .vout(kout));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int j = 0; j < R; j++) begin
            coll[j] <= '0;
            bank[j] <= '0;
         end
      end else if (land_vld) begin
         coll[land_k] <= operand;
         if (land_last) begin
            for (int j = 0; j < R; j++) bank[j] <= kout[j*W +: W];
         end
      end
   end

   assign out_word = bank[out_sel];

endmodule

// File: rtl/fht_store.sv
// Sample array: one write port, a registered engine read and a registered host read.
module fht_store #(
   parameter int W     = 12,
   parameter int DEPTH = 64,
   parameter int ADDRW = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [ADDRW-1:0] waddr,
   input  logic [W-1:0]     wdata,
   input  logic             eng_re,
   input  logic [ADDRW-1:0] eng_raddr,
   output logic [W-1:0]     eng_q,
   input  logic             host_re,
   input  logic [ADDRW-1:0] host_raddr,
   output logic [W-1:0]     host_q
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         eng_q <= '0;
      else if (eng_re) eng_q <= mem[eng_raddr];
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)          host_q <= '0;
      else if (host_re) host_q <= mem[host_raddr];
   end

   assert_host_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !host_re |=> $stable(host_q));

endmodule

// File: rtl/fht_ctrl.sv
// Pass sequencer: per pass, POINTS read issues followed by an R+1 cycle drain.
module fht_ctrl #(
   parameter int POINTS = 64,
   parameter int R      = 4,
   parameter int PASSES = 3,
   parameter int PW     = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      run_en,
   output logic [PW-1:0]             pass,
   output logic                      rd_go,
   output logic [$clog2(POINTS)-1:0] rd_idx,
   output logic                      land_vld,
   output logic [$clog2(R)-1:0]      land_k,
   output logic                      wr_go,
   output logic [$clog2(POINTS)-1:0] wr_idx,
   output logic                      done
);
   import fht_pkg::*;

   localparam int ADDRW   = $clog2(POINTS);
   localparam int LOGR    = $clog2(R);
   localparam int PIPE    = R + 1;
   localparam int PASSLEN = POINTS + PIPE;
   localparam int CW      = $clog2(PASSLEN);

   fht_state_t       state;
   logic [CW-1:0]    cnt;
   logic             rd_v;
   logic             step;
   logic             last_cyc;
   logic [CW-1:0]    wr_off;

   assign step     = (state == ST_RUN) && run_en;
   assign last_cyc = (cnt == CW'(PASSLEN - 1));
   assign rd_go    = step && (cnt < CW'(POINTS));
   assign rd_idx   = cnt[ADDRW-1:0];
   assign wr_off   = cnt - CW'(PIPE);
   assign wr_go    = step && (cnt >= CW'(PIPE));
   assign wr_idx   = wr_off[ADDRW-1:0];
   assign land_vld = rd_v && step;
   assign done     = (state == ST_DONE);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state <= ST_IDLE;
         cnt   <= '0;
         pass  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (run_en) begin
               state <= ST_RUN;
               cnt   <= '0;
               pass  <= '0;
            end
            ST_RUN: if (run_en) begin
               if (last_cyc) begin
                  cnt <= '0;
                  if (pass == PW'(PASSES - 1)) state <= ST_DONE;
                  else                         pass  <= pass + PW'(1);
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_DONE: if (!run_en) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Operand landing pipeline: tracks the read issued one cycle earlier
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_v   <= 1'b0;
         land_k <= '0;
      end else if (step) begin
         rd_v   <= (cnt < CW'(POINTS));
         land_k <= cnt[LOGR-1:0];
      end else if (state != ST_RUN) begin
         rd_v   <= 1'b0;
      end
   end

   assert_pause_freeze_R6: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RUN && !run_en) |=> (state == ST_RUN && $stable(cnt) && $stable(pass)));

   assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (done && run_en) |=> done);

   assert_done_drop_R7: assert property (@(posedge clk) disable iff (rst)
      (done && !run_en) |=> !done);

endmodule

// File: rtl/fht_engine.sv
module fht_engine #(
   parameter int POINTS    = 64,
   parameter int RADIX     = 4,
   parameter int DATAWIDTH = 12,
   localparam int ADDRW    = $clog2(POINTS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 run_en,
   input  logic                 wr_en,
   input  logic [ADDRW-1:0]     wr_addr,
   input  logic [DATAWIDTH-1:0] wr_data,
   input  logic                 rd_en,
   input  logic [ADDRW-1:0]     rd_addr,
   output logic [DATAWIDTH-1:0] rd_data,
   output logic                 xform_done
);
   localparam int LOGR   = $clog2(RADIX);
   localparam int PASSES = ADDRW / LOGR;
   localparam int PW     = $clog2(PASSES + 1);

   if (RADIX != 2 && RADIX != 4 && RADIX != 8) begin : g_bad_radix
      $error("fht_engine: RADIX must be 2, 4 or 8");
   end
   if ((1 << ADDRW) != POINTS || (ADDRW % LOGR) != 0 || POINTS < RADIX) begin : g_bad_points
      $error("fht_engine: POINTS must be a power of RADIX");
   end
   if (DATAWIDTH < 2) begin : g_bad_width
      $error("fht_engine: DATAWIDTH must be at least 2");
   end

   logic [PW-1:0]        pass;
   logic                 rd_go;
   logic [ADDRW-1:0]     rd_idx;
   logic                 land_vld;
   logic [LOGR-1:0]      land_k;
   logic                 wr_go;
   logic [ADDRW-1:0]     wr_idx;
   logic [ADDRW-1:0]     eng_raddr;
   logic [ADDRW-1:0]     eng_waddr;
   logic [DATAWIDTH-1:0] eng_q;
   logic [DATAWIDTH-1:0] bfly_word;
   logic                 mem_we;
   logic [ADDRW-1:0]     mem_waddr;
   logic [DATAWIDTH-1:0] mem_wdata;

   fht_ctrl #(.POINTS(POINTS), .R(RADIX), .PASSES(PASSES), .PW(PW)) u_ctrl (
      .clk(clk), .rst(rst), .run_en(run_en), .pass(pass),
      .rd_go(rd_go), .rd_idx(rd_idx), .land_vld(land_vld), .land_k(land_k),
      .wr_go(wr_go), .wr_idx(wr_idx), .done(xform_done)
   );

   fht_addr_map #(.ADDRW(ADDRW), .LOGR(LOGR), .PW(PW)) u_rmap (
      .idx(rd_idx), .pass(pass), .addr(eng_raddr)
   );

   fht_addr_map #(.ADDRW(ADDRW), .LOGR(LOGR), .PW(PW)) u_wmap (
      .idx(wr_idx), .pass(pass), .addr(eng_waddr)
   );

   fht_bfly_stage #(.W(DATAWIDTH), .R(RADIX)) u_bfly (
      .clk(clk), .rst(rst), .land_vld(land_vld), .land_k(land_k),
      .operand(eng_q), .out_sel(wr_idx[LOGR-1:0]), .out_word(bfly_word)
   );

   // Host writes only while the engine is held off
   assign mem_we    = wr_go | (wr_en & ~run_en);
   assign mem_waddr = wr_go ? eng_waddr : wr_addr;
   assign mem_wdata = wr_go ? bfly_word : wr_data;

   fht_store #(.W(DATAWIDTH), .DEPTH(POINTS), .ADDRW(ADDRW)) u_store (
      .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .eng_re(rd_go), .eng_raddr(eng_raddr), .eng_q(eng_q),
      .host_re(rd_en), .host_raddr(rd_addr), .host_q(rd_data)
   );

   assert_done_after_write_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(xform_done) |-> $past(wr_go));

   assert_no_host_write_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && run_en && !wr_go) |-> !mem_we);

endmodule

// File: tb/tb_fht_engine.sv
module tb_fht_engine;
   localparam int N      = 64;
   localparam int R      = 4;
   localparam int W      = 12;
   localparam int L      = 2;
   localparam int AW     = 6;
   localparam int PASSES = 3;
   localparam int BUDGET = 1 + PASSES * (N + R + 1);
   localparam int MAXV   = (1 << (W - 1)) - 1;
   localparam int MINV   = -(1 << (W - 1));

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          run_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic          xform_done;

   int total = 0;
   int bad = 0;
   int vec [N];
   int ref_v [N];

   always #4 clk = ~clk;

   fht_engine #(.POINTS(N), .RADIX(R), .DATAWIDTH(W)) dut (
      .clk(clk), .rst(rst), .run_en(run_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .xform_done(xform_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Pass-by-pass model built from the butterfly, rounding and clamp rules
   function automatic void model();
      int s;
      int x [R];
      int sum;
      int v;
      s = 1;
      for (int i = 0; i < N; i++) ref_v[i] = vec[i];
      for (int p = 0; p < PASSES; p++) begin
         for (int b = 0; b < N; b++) begin
            if (((b / s) % R) == 0) begin
               for (int j = 0; j < R; j++) x[j] = ref_v[b + j * s];
               for (int k = 0; k < R; k++) begin
                  sum = 0;
                  for (int j = 0; j < R; j++) begin
                     if (($countones(k & j) % 2) == 1) sum -= x[j];
                     else                               sum += x[j];
                  end
                  v = (sum + R / 2) >>> L;
                  if (v > MAXV) v = MAXV;
                  if (v < MINV) v = MINV;
                  ref_v[b + k * s] = v;
               end
            end
         end
         s = s * R;
      end
   endfunction

   task automatic load_all();
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(i); wr_data = W'(vec[i]);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_word(input int a, output int val);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      val = int'($signed(rd_data));
   endtask

   task automatic check_all(input string req);
      int val;
      for (int i = 0; i < N; i++) begin
         read_word(i, val);
         chk(req, val, ref_v[i]);
      end
   endtask

   task automatic run_count(output int n);
      @(negedge clk);
      run_en = 1'b1;
      n = 0;
      while (!xform_done && n < 4 * BUDGET) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic rand_vec(input int amp);
      for (int i = 0; i < N; i++) vec[i] = int'($urandom_range(0, 2 * amp)) - amp;
   endtask

   task automatic full_cycle(input string req);
      int n;
      load_all();
      model();
      run_count(n);
      chk("R5 done edge", n, BUDGET);
      @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int val;
      int held;
      void'($urandom(32'd20240611));

      // R8: reset state
      #3;
      chk("R8 reset done", int'(xform_done), 0);
      chk("R8 reset rd_data", int'(rd_data), 0);
      @(negedge clk);
      rst = 1'b0;

      // R1: host write then read back, no transform
      rand_vec(2000);
      load_all();
      for (int i = 0; i < N; i += 7) begin
         read_word(i, val);
         chk("R1 readback", val, vec[i]);
      end

      // R9: read data holds while rd_en is low
      read_word(5, held);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         rd_addr = AW'(c + 20);
         chk("R9 hold", int'($signed(rd_data)), held);
      end

      // R3/R5/R7/R2: impulse transform, then done behaviour
      for (int i = 0; i < N; i++) vec[i] = 0;
      vec[0] = 1280;
      load_all();
      model();
      run_count(n);
      chk("R5 done edge", n, BUDGET);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk("R7 done held", int'(xform_done), 1);
      end
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(5); wr_data = W'(777);
      @(negedge clk);
      wr_en = 1'b0;
      run_en = 1'b0;
      @(negedge clk);
      chk("R7 done cleared", int'(xform_done), 0);
      read_word(5, val);
      chk("R2 write ignored", val, ref_v[5]);
      check_all("R3 impulse");

      // R3: constant and random vectors
      for (int i = 0; i < N; i++) vec[i] = 300;
      full_cycle("R3 constant");
      rand_vec(500);
      full_cycle("R3 random small");
      rand_vec(1500);
      full_cycle("R3 random mid");

      // R4: alternating full scale drives outputs past the range
      for (int i = 0; i < N; i++) vec[i] = (i % 2 == 0) ? MAXV : MINV;
      full_cycle("R4 clamp");
      rand_vec(2047);
      full_cycle("R4 random full scale");

      // R6: pause partway through a pass
      rand_vec(1000);
      load_all();
      model();
      @(negedge clk);
      run_en = 1'b1;
      n = 0;
      for (int c = 0; c < 41; c++) begin
         @(negedge clk);
         n++;
      end
      run_en = 1'b0;
      for (int c = 0; c < 17; c++) begin
         @(negedge clk);
         n++;
      end
      chk("R6 no done while paused", int'(xform_done), 0);
      run_en = 1'b1;
      while (!xform_done && n < 4 * BUDGET) begin
         @(negedge clk);
         n++;
      end
      chk("R6 delayed done edge", n, BUDGET + 17);
      @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      check_all("R6 results after pause");

      // R8: asynchronous reset during a transform
      rand_vec(800);
      load_all();
      @(negedge clk);
      run_en = 1'b1;
      for (int c = 0; c < 30; c++) @(negedge clk);
      #1;
      rst = 1'b1;
      #1;
      chk("R8 async done", int'(xform_done), 0);
      chk("R8 async rd_data", int'(rd_data), 0);
      run_en = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk("R8 aborted", int'(xform_done), 0);
      end
      rand_vec(900);
      full_cycle("R8 fresh run after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule